// File: doc/BRIEF.md
# Trimmed Nanosecond Time Counter

This block keeps a 40-bit nanosecond time value that moves forward by a fixed 8 ns on every cycle of an 8 ns clock. The base step is hardwired. The rate is trimmed by a signed fractional correction. A 32-bit sub-nanosecond accumulator receives a programmed magnitude on every cycle, either added or subtracted according to a sign bit. When the accumulator overflows, that cycle's step becomes 9 ns. When it underflows, the step becomes 7 ns. The nanosecond field wraps modulo 2^40, which is about 18.3 minutes.

Software reaches the block through a small register port. A 3-bit address selects one of five registers:

- Sub-nanosecond fraction: address 0.
- Low nanosecond word: address 1.
- High nanosecond word: address 2.
- Rate trim: address 3.
- Run control: address 4.

Reading the fraction register also freezes a copy of the nanosecond count. The low-word and high-word reads that follow return that frozen copy, so a multi-word read stays coherent while the clock keeps running. The counter stays stopped while the halt bit is set, and the halt bit comes out of reset set. A rate trim for an offset of N ppb is (N << 26) / 1953125. The largest supported offset, 62,499,999 ppb, gives magnitude 0x7FFFFFDD.

Top module: `tnc_trim_clock`

## Requirements
- R1: After reset the following hold: halt bit set (run-control reads 0x80000000), trim register 0, nanosecond count 0, fraction 0, snapshot 0.
- R2: While run-control bit 31 is 1, neither the nanosecond count nor the fraction changes.
- R3: With trim magnitude 0 and halt clear, the count grows by exactly 8 each cycle.
- R4: With trim bit 31 = 0, the magnitude (bits 30:0) is added to the 32-bit fraction each running cycle. A carry out of bit 31 makes that cycle's step 9 ns.
- R5: With trim bit 31 = 1, the magnitude is subtracted from the fraction each running cycle. A borrow makes that cycle's step 7 ns.
- R6: The nanosecond count wraps modulo 2^40.
- R7: A read's data appears on rdata in the cycle after rd_en. A read of address 0 returns the fraction and captures the current count. Reads of addresses 1 and 2 return the captured count and are not affected by later counting.
- R8: A read of address 2 returns the count's bits 39:32 in rdata bits 7:0. rdata bits 31:8 read as zero, even after all-ones is written.
- R9: A write to address 1 loads count bits 31:0. A write to address 2 loads count bits 39:32 from wdata bits 7:0. Each write keeps the other half and clears the fraction. A load overrides counting in that cycle.
- R10: The trim register (address 3) reads back as written. Run control (address 4) keeps only bit 31 and reads back {halt, 31 zeros}. Addresses 5 to 7 read as zero.
- R11: The maximum trim of 62,499,999 ppb (magnitude 0x7FFFFFDD, positive) advances the count according to R4 with no loss of carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 8 ns time base clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register select |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |

## Verification
A wrong fraction shows up at the ports as a count that is off by one nanosecond per missed carry or borrow, and the error grows in proportion to the number of running cycles. It is therefore measured over windows of known length with known magnitudes, and the expected value is compared in closed form. A stale or torn snapshot appears on the very next low-word or high-word read once the counter has moved since the fraction read. A halt or load fault shows in the first read after the stimulus.

// File: rtl/tnc_pkg.sv
package tnc_pkg;
  localparam int unsigned TNC_ADDR_W = 3;

  typedef enum logic [TNC_ADDR_W-1:0] {
    TNC_REG_SUBNS = 3'd0,
    TNC_REG_NSLO  = 3'd1,
    TNC_REG_NSHI  = 3'd2,
    TNC_REG_TRIM  = 3'd3,
    TNC_REG_RUN   = 3'd4
  } tnc_reg_e;
endpackage

// File: rtl/tnc_frac_acc.sv
module tnc_frac_acc #(
  parameter int unsigned FRAC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clr,
  input  logic              sign,
  input  logic [FRAC_W-2:0] mag,
  output logic [FRAC_W-1:0] frac,
  output logic              step_up,
  output logic              step_dn
);
  localparam int unsigned EXT_W = FRAC_W + 1;

  logic [FRAC_W-1:0] frac_q, frac_d;
  logic [EXT_W-1:0]  sum, dif;

  always_comb begin
    sum     = {1'b0, frac_q} + {2'b00, mag};
    dif     = {1'b0, frac_q} - {2'b00, mag};
    frac_d  = frac_q;
    step_up = 1'b0;
    step_dn = 1'b0;
    if (clr) begin
      frac_d = '0;
    end else if (run) begin
      if (sign) begin
        frac_d  = dif[FRAC_W-1:0];
        step_dn = dif[FRAC_W];
      end else begin
        frac_d  = sum[FRAC_W-1:0];
        step_up = sum[FRAC_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frac_q <= '0;
    else        frac_q <= frac_d;
  end

  assign frac = frac_q;

  AST_FRAC_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (frac_q == '0)); // R9
  AST_FRAC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(frac_q)); // R2
endmodule

// File: rtl/tnc_ns_ctr.sv
module tnc_ns_ctr #(
  parameter int unsigned NS_W      = 40,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned BASE_STEP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              step_up,
  input  logic              step_dn,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [DATA_W-1:0] ld_data,
  output logic [NS_W-1:0]   ns
);
  localparam int unsigned HI_W = NS_W - DATA_W;

  logic [NS_W-1:0] ns_q, ns_d, step;

  always_comb begin
    step = NS_W'(BASE_STEP) + NS_W'(step_up) - NS_W'(step_dn);
    ns_d = ns_q;
    if (ld_lo || ld_hi) begin
      if (ld_lo) ns_d[DATA_W-1:0]    = ld_data;
      if (ld_hi) ns_d[NS_W-1:DATA_W] = ld_data[HI_W-1:0];
    end else if (run) begin
      ns_d = ns_q + step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ns_q <= '0;
    else        ns_q <= ns_d;
  end

  assign ns = ns_q;

  AST_HOLD_WHEN_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld_lo && !ld_hi) |=> $stable(ns_q)); // R2
  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ld_lo && !ld_hi) |=>
      (NS_W'(ns_q - $past(ns_q)) >= NS_W'(BASE_STEP - 1)) &&
      (NS_W'(ns_q - $past(ns_q)) <= NS_W'(BASE_STEP + 1))); // R3
endmodule

// File: rtl/tnc_regif.sv
module tnc_regif
  import tnc_pkg::*;
#(
  parameter int unsigned NS_W   = 40,
  parameter int unsigned DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [TNC_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [DATA_W-1:0]     frac,
  input  logic [NS_W-1:0]       ns,
  output logic                  halt,
  output logic                  trim_sign,
  output logic [DATA_W-2:0]     trim_mag,
  output logic                  ld_lo,
  output logic                  ld_hi,
  output logic [DATA_W-1:0]     rdata
);
  localparam int unsigned HI_W = NS_W - DATA_W;

  logic [DATA_W-1:0] trim_q, trim_d;
  logic              halt_q, halt_d;
  logic [NS_W-1:0]   snap_q, snap_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rd_sub;

  assign ld_lo  = wr_en && (addr == TNC_REG_NSLO);
  assign ld_hi  = wr_en && (addr == TNC_REG_NSHI);
  assign rd_sub = rd_en && (addr == TNC_REG_SUBNS);

  always_comb begin
    trim_d  = trim_q;
    halt_d  = halt_q;
    snap_d  = snap_q;
    rdata_d = rdata_q;
    if (wr_en && addr == TNC_REG_TRIM) trim_d = wdata;
    if (wr_en && addr == TNC_REG_RUN)  halt_d = wdata[DATA_W-1];
    if (rd_sub) snap_d = ns;
    if (rd_en) begin
      case (addr)
        TNC_REG_SUBNS: rdata_d = frac;
        TNC_REG_NSLO:  rdata_d = snap_q[DATA_W-1:0];
        TNC_REG_NSHI:  rdata_d = DATA_W'(snap_q[NS_W-1:DATA_W]);
        TNC_REG_TRIM:  rdata_d = trim_q;
        TNC_REG_RUN:   rdata_d = {halt_q, {(DATA_W-1){1'b0}}};
        default:       rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trim_q  <= '0;
      halt_q  <= 1'b1;
      snap_q  <= '0;
      rdata_q <= '0;
    end else begin
      trim_q  <= trim_d;
      halt_q  <= halt_d;
      snap_q  <= snap_d;
      rdata_q <= rdata_d;
    end
  end

  assign halt      = halt_q;
  assign trim_sign = trim_q[DATA_W-1];
  assign trim_mag  = trim_q[DATA_W-2:0];
  assign rdata     = rdata_q;

  AST_HI_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == TNC_REG_NSHI) |=> (rdata_q[DATA_W-1:HI_W] == '0)); // R8
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sub |=> $stable(snap_q)); // R7
  AST_RUN_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == TNC_REG_RUN) |=> (halt_q == $past(wdata[DATA_W-1]))); // R10
endmodule

// File: rtl/tnc_trim_clock.sv
module tnc_trim_clock
  import tnc_pkg::*;
#(
  parameter int unsigned NS_W      = 40,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned BASE_STEP = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [TNC_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata
);
  localparam int unsigned FRAC_W = DATA_W;

  logic [1:0]        rst_sync;
  logic              rst_i_n;
  logic              halt, trim_sign, ld_lo, ld_hi, step_up, step_dn;
  logic [DATA_W-2:0] trim_mag;
  logic [FRAC_W-1:0] frac;
  logic [NS_W-1:0]   ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  tnc_regif #(.NS_W(NS_W), .DATA_W(DATA_W)) u_regif (
    .clk(clk), .rst_n(rst_i_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .frac(frac), .ns(ns), .halt(halt), .trim_sign(trim_sign),
    .trim_mag(trim_mag), .ld_lo(ld_lo), .ld_hi(ld_hi), .rdata(rdata)
  );

  tnc_frac_acc #(.FRAC_W(FRAC_W)) u_frac (
    .clk(clk), .rst_n(rst_i_n), .run(!halt), .clr(ld_lo || ld_hi),
    .sign(trim_sign), .mag(trim_mag), .frac(frac),
    .step_up(step_up), .step_dn(step_dn)
  );

  tnc_ns_ctr #(.NS_W(NS_W), .DATA_W(DATA_W), .BASE_STEP(BASE_STEP)) u_ctr (
    .clk(clk), .rst_n(rst_i_n), .run(!halt), .step_up(step_up),
    .step_dn(step_dn), .ld_lo(ld_lo), .ld_hi(ld_hi), .ld_data(wdata), .ns(ns)
  );
endmodule

// File: tb/tb_tnc_trim_clock.sv
module tb_tnc_trim_clock;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [2:0]  addr;
  logic [31:0] wdata, rdata;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  typedef struct packed {
    logic [31:0] trim;
    logic [39:0] start;
    logic [15:0] n;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{32'h0000_0000, 40'd1000,          16'd10}, // R3
    '{32'h4000_0000, 40'h12_3456_7890,  16'd8},  // R4
    '{32'hC000_0000, 40'd500,           16'd8},  // R5
    '{32'h7FFF_FFFF, 40'd0,             16'd5},  // R4
    '{32'h0000_0000, 40'hFF_FFFF_FFF0,  16'd4},  // R6
    '{32'hFFFF_FFFF, 40'd5,             16'd3},  // R5
    '{32'h0000_0001, 40'hFF_FFFF_FFFC,  16'd1}   // R6
  };

  tnc_trim_clock dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic read_time(output logic [31:0] f, output logic [39:0] t);
    logic [31:0] lo, hi;
    rd(3'd0, f);
    rd(3'd1, lo);
    rd(3'd2, hi);
    t = {hi[7:0], lo};
  endtask

  // closed-form result of n running cycles from a freshly loaded count
  task automatic model(input logic [31:0] trim, input logic [39:0] start,
                       input int n, output logic [39:0] t, output logic [31:0] f);
    logic [63:0] total, adj;
    total = 64'(trim[30:0]) * 64'(n);
    if (!trim[31]) begin
      adj = total >> 32;
      f   = total[31:0];
      t   = start + 40'(8 * n) + adj[39:0];
    end else begin
      adj = (total + 64'hFFFF_FFFF) >> 32;
      f   = 32'(64'd0 - total);
      t   = start + 40'(8 * n) - adj[39:0];
    end
  endtask

  task automatic run_vec(input logic [31:0] trim, input logic [39:0] start,
                         input int n, input string req);
    logic [31:0] f, ef;
    logic [39:0] t, et;
    wr(3'd3, trim);
    wr(3'd1, start[31:0]);
    wr(3'd2, {24'h0, start[39:32]});
    wr(3'd4, 32'h0);
    repeat (n - 1) @(negedge clk);
    wr(3'd4, 32'h8000_0000);
    read_time(f, t);
    model(trim, start, n, et, ef);
    chk({req, " count"}, 64'(t), 64'(et));
    chk({req, " fraction"}, 64'(f), 64'(ef));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, f;
    logic [39:0] t;
    logic [63:0] ppb_mag;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(3'd4, d); chk("R1 run control", 64'(d), 64'h8000_0000);
    rd(3'd3, d); chk("R1 trim", 64'(d), 64'h0);
    rd(3'd1, d); chk("R1 snapshot", 64'(d), 64'h0);
    read_time(f, t);
    chk("R1 fraction", 64'(f), 64'h0);
    chk("R1 count", 64'(t), 64'h0);

    // R2 halted: trim set but nothing moves
    wr(3'd3, 32'h4000_0000);
    repeat (20) @(negedge clk);
    read_time(f, t);
    chk("R2 count frozen", 64'(t), 64'h0);
    chk("R2 fraction frozen", 64'(f), 64'h0);

    // R10 readback
    wr(3'd3, 32'h8000_1234);
    rd(3'd3, d); chk("R10 trim readback", 64'(d), 64'h8000_1234);
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, d); chk("R10 run readback", 64'(d), 64'h8000_0000);
    rd(3'd6, d); chk("R10 unused address", 64'(d), 64'h0);

    // R8 / R9 partial loads and reserved bits
    wr(3'd1, 32'h0000_0005);
    wr(3'd2, 32'hFFFF_FFAB);
    rd(3'd0, d);
    rd(3'd2, d); chk("R8 high word reserved bits", 64'(d), 64'h0000_00AB);
    rd(3'd1, d); chk("R9 low word kept by high load", 64'(d), 64'h5);

    // table of running windows
    foreach (VECS[i]) run_vec(VECS[i].trim, VECS[i].start, int'(VECS[i].n), $sformatf("vec%0d R3 R4 R5 R6", i));

    // R11 maximum ppb trim
    ppb_mag = (64'd62499999 << 26) / 64'd1953125;
    chk("R11 ppb magnitude", ppb_mag, 64'h7FFF_FFDD);
    run_vec(32'(ppb_mag), 40'd7777, 6, "R11 max trim");

    // R9 load clears fraction
    wr(3'd3, 32'h4000_0000);
    wr(3'd1, 32'd0); wr(3'd2, 32'd0);
    wr(3'd4, 32'h0);
    repeat (2) @(negedge clk);
    wr(3'd4, 32'h8000_0000);
    rd(3'd0, d); chk("R4 fraction after 3 cycles", 64'(d), 64'hC000_0000);
    wr(3'd1, 32'd50);
    rd(3'd0, d); chk("R9 fraction cleared by load", 64'(d), 64'h0);

    // R7 snapshot coherence while running
    wr(3'd3, 32'h0);
    wr(3'd1, 32'd100); wr(3'd2, 32'd0);
    wr(3'd4, 32'h0);
    rd(3'd0, d);
    repeat (5) @(negedge clk);
    rd(3'd1, d); chk("R7 low word from snapshot", 64'(d), 64'd100);
    rd(3'd2, d); chk("R7 high word from snapshot", 64'(d), 64'd0);
    wr(3'd4, 32'h8000_0000);
    read_time(f, t);
    chk("R3 count after 9 running cycles", 64'(t), 64'd172);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule